// File: doc/BRIEF.md
# Interleaved Quadword Address Generator

This block produces the memory address stream for a single DMA channel that moves data with a fixed stride. The stride is a run of transferred quadwords followed by a gap of skipped quadwords. A quadword is 16 bytes. After one start strobe, the block emits one 16-byte-aligned address per accepted beat. It moves `xfer` quadwords, jumps over `skip` quadwords without emitting anything, and repeats this pattern. It stops when the total quadword count has been emitted. Only transferred quadwords count toward the total. When the run ends, the block raises a one-cycle done pulse.

The address output is a valid/ready stream. The block holds `addr_valid` high and `addr` stable until the consumer raises `addr_ready` in the same cycle. A beat is taken only when both are high, and the consumer may stall for any number of cycles. The start strobe and the done pulse are plain control pins. A start seen while a run is in progress is ignored.

The transfer and skip counts arrive packed in one 32-bit stride configuration word. The transfer count sits in bits 23:16 and the skip count in bits 7:0. Every other bit of that word has no effect.

Top module: `ilv_agen`

## Requirements
- R1: After reset, `addr_valid` and `done` are both low until a start is accepted.
- R2: Every address emitted has bits 3:0 equal to zero, and the first address of a run is `base_addr` with bits 3:0 cleared.
- R3: Within a group, each accepted beat is followed by an address 16 higher, modulo 2^ADDR_W.
- R4: After the last beat of a group of `xfer` beats, the next address is 16*(1+skip) above the previous one, and no beat is emitted for the skipped quadwords.
- R5: A run with non-zero counts emits exactly `total_qw` beats. `done` is high for exactly one cycle: the cycle right after the handshake of the final beat. `addr_valid` is low in that cycle.
- R6: When a start is accepted with `total_qw` = 0 or a transfer count of 0, no beat is emitted and `done` is high in the cycle right after the start.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr` stays unchanged in the next cycle.
- R8: A start strobe that arrives while a run is in progress (including its done cycle) does not change the address stream or the beat count of that run.
- R9: The transfer count is taken from bits 23:16 and the skip count from bits 7:0 of `stride_cfg`. The values of bits 31:24 and 15:8 have no effect.
- R10: If `total_qw` is not a multiple of the transfer count, the run stops in the middle of the last group after exactly `total_qw` beats and signals done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| base_addr | input | ADDR_W | Byte start address; low 4 bits ignored |
| total_qw | input | TOTAL_W | Number of quadwords to transfer |
| stride_cfg | input | CFG_W | Transfer count in [23:16], skip count in [7:0] |
| addr_valid | output | 1 | Address beat offered |
| addr_ready | input | 1 | Consumer accepts the offered beat |
| addr | output | ADDR_W | Quadword-aligned byte address |
| done | output | 1 | One-cycle pulse at end of run |

## Verification
The sweep covers every combination of total counts 0 to 9, transfer counts 0 to 4 and skip counts 0 to 3. Totals that divide the group size evenly separate correct group-boundary jumps (R4) from correct plain steps (R3). Totals that do not divide evenly expose an early or late stop inside a partial group (R10). Zero counts show the immediate-completion path (R6).

Consumer back-pressure is varied between always-ready and periodic stalls, so hold behaviour is checked against both single-cycle and back-to-back acceptance. Further runs cover these cases:
- Junk in the unused configuration bits (R9).
- A second start strobe in the middle of a run (R8).
- A base address that wraps past the top of the address space.
- Maximal 255/255 counts, which land a group boundary well inside a long run.

// File: rtl/ilv_agen_pkg.sv
package ilv_agen_pkg;
  localparam int QW_SHIFT  = 4;
  localparam int CNT_W     = 8;
  localparam int XFER_LSB  = 16;
  localparam int SKIP_LSB  = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ilv_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] xfer;
    logic [CNT_W-1:0] skip;
  } stride_t;
endpackage

// File: rtl/ilv_cfg_decode.sv
module ilv_cfg_decode
  import ilv_agen_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg_word,
  output stride_t          stride
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_word;

  always_comb begin
    stride.xfer = cfg_word[XFER_LSB +: CNT_W];
    stride.skip = cfg_word[SKIP_LSB +: CNT_W];
  end
endmodule

// File: rtl/ilv_beat_tracker.sv
module ilv_beat_tracker
  import ilv_agen_pkg::*;
#(
  parameter int TOTAL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TOTAL_W-1:0] total,
  input  logic [CNT_W-1:0]   grp_len,
  input  logic               advance,
  output logic               last_beat,
  output logic               group_end
);
  localparam int POS_W = CNT_W + 1;

  logic [TOTAL_W-1:0] remain_q;
  logic [CNT_W-1:0]   pos_q;
  logic [CNT_W-1:0]   len_q;
  logic [POS_W-1:0]   pos_next;

  assign pos_next  = {1'b0, pos_q} + POS_W'(1);
  assign group_end = (pos_next == {1'b0, len_q});
  assign last_beat = (remain_q == TOTAL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      pos_q    <= '0;
      len_q    <= '0;
    end else if (load) begin
      remain_q <= total;
      pos_q    <= '0;
      len_q    <= grp_len;
    end else if (advance) begin
      remain_q <= remain_q - TOTAL_W'(1);
      pos_q    <= group_end ? '0 : pos_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/ilv_addr_step.sv
module ilv_addr_step
  import ilv_agen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  skip,
  input  logic              advance,
  input  logic              group_end,
  output logic [ADDR_W-1:0] addr
);
  localparam int QA_W = ADDR_W - QW_SHIFT;

  logic [QA_W-1:0]  qa_q;
  logic [CNT_W-1:0] skip_q;
  logic [QA_W-1:0]  stride_jump;
  logic             unused_low;

  assign unused_low  = ^base[QW_SHIFT-1:0];
  assign stride_jump = QA_W'(skip_q) + QA_W'(1);
  assign addr        = {qa_q, {QW_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qa_q   <= '0;
      skip_q <= '0;
    end else if (load) begin
      qa_q   <= base[ADDR_W-1:QW_SHIFT];
      skip_q <= skip;
    end else if (advance) begin
      qa_q   <= qa_q + (group_end ? stride_jump : QA_W'(1));
    end
  end
endmodule

// File: rtl/ilv_agen.sv
module ilv_agen
  import ilv_agen_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TOTAL_W = 16,
  parameter int CFG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [TOTAL_W-1:0] total_qw,
  input  logic [CFG_W-1:0]   stride_cfg,
  output logic               addr_valid,
  input  logic               addr_ready,
  output logic [ADDR_W-1:0]  addr,
  output logic               done
);
  ilv_state_e state_q;
  stride_t    stride;
  logic       accept;
  logic       empty_run;
  logic       beat_hs;
  logic       last_beat;
  logic       group_end;

  ilv_cfg_decode #(.CFG_W(CFG_W)) u_dec (
    .cfg_word (stride_cfg),
    .stride   (stride)
  );

  assign accept     = (state_q == ST_IDLE) && start;
  assign empty_run  = (total_qw == '0) || (stride.xfer == '0);
  assign addr_valid = (state_q == ST_RUN);
  assign done       = (state_q == ST_FIN);
  assign beat_hs    = addr_valid && addr_ready;

  ilv_beat_tracker #(.TOTAL_W(TOTAL_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .total     (total_qw),
    .grp_len   (stride.xfer),
    .advance   (beat_hs),
    .last_beat (last_beat),
    .group_end (group_end)
  );

  ilv_addr_step #(.ADDR_W(ADDR_W)) u_adr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .base      (base_addr),
    .skip      (stride.skip),
    .advance   (beat_hs),
    .group_end (group_end),
    .addr      (addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= empty_run ? ST_FIN : ST_RUN;
        ST_RUN:  if (beat_hs && last_beat) state_q <= ST_FIN;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_agen_checker.sv
module ilv_agen_checker #(
  parameter int ADDR_W  = 32,
  parameter int TOTAL_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [TOTAL_W-1:0] total_qw,
  input logic               addr_valid,
  input logic               addr_ready,
  input logic [ADDR_W-1:0]  addr,
  input logic               done
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     busy_q <= 1'b0;
    else if (done)  busy_q <= 1'b0;
    else if (start) busy_q <= 1'b1;
  end

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr[3:0] == 4'h0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr)));

  a_r5_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  a_r6_empty_total: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && (total_qw == '0)) |=> done);
endmodule

bind ilv_agen ilv_agen_checker #(.ADDR_W(ADDR_W), .TOTAL_W(TOTAL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .total_qw   (total_qw),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr       (addr),
  .done       (done)
);

// File: tb/tb_ilv_agen.sv
module tb_ilv_agen;
  localparam int ADDR_W  = 32;
  localparam int TOTAL_W = 16;
  localparam int CFG_W   = 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic [ADDR_W-1:0]  base_addr;
  logic [TOTAL_W-1:0] total_qw;
  logic [CFG_W-1:0]   stride_cfg;
  logic               addr_valid;
  logic               addr_ready;
  logic [ADDR_W-1:0]  addr;
  logic               done;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ilv_agen #(.ADDR_W(ADDR_W), .TOTAL_W(TOTAL_W), .CFG_W(CFG_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .total_qw(total_qw), .stride_cfg(stride_cfg), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr(addr), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int i,
                                           input int x, input int s);
    int g;
    g = i / x;
    return (base & ~32'hF) + 32'((i + g * s) * 16);
  endfunction

  task automatic run(input logic [31:0] base, input int total, input int x,
                     input int s, input int seed, input bit poke,
                     input logic [7:0] junk, input string note);
    int beats = 0;
    int exp_n;
    int cyc = 0;
    bit seen_done = 0;
    bit prev_hs = 0;
    bit hold_prev = 0;
    bit rdy;
    logic [31:0] held = '0;
    string tag;
    exp_n = (x == 0 || total == 0) ? 0 : total;
    @(negedge clk);
    base_addr  = base;
    total_qw   = TOTAL_W'(total);
    stride_cfg = {junk, 8'(x), ~junk, 8'(s)};
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
    base_addr  = 32'hDEAD_BEEF;
    total_qw   = 16'h0003;
    stride_cfg = 32'h0001_0001;
    while (!seen_done && cyc < 2000) begin
      rdy = 1'b0;
      start = 1'b0;
      if (hold_prev) begin
        check(addr_valid && addr == held, "R7", {"hold ", note}, addr, held);
        hold_prev = 0;
      end
      if (done) begin
        seen_done = 1;
        if (exp_n == 0) tag = "R6";
        else if (total % x != 0) tag = "R10";
        else tag = "R5";
        check(beats == exp_n, tag, {"beat count ", note}, beats, exp_n);
        check(exp_n == 0 ? cyc == 0 : prev_hs, tag, {"done timing ", note}, cyc, 0);
        check(!addr_valid, "R5", {"valid with done ", note}, addr_valid, 0);
      end else if (addr_valid) begin
        if (seed % 4 == 0) rdy = 1'b1;
        else rdy = ((cyc + seed) % (seed % 4 + 1)) != 0;
        if (poke && cyc == 3) begin
          start = 1'b1;
          total_qw = 16'h0001;
          stride_cfg = 32'h0001_0005;
        end
        if (rdy) begin
          if (beats >= exp_n) begin
            check(0, "R5", {"extra beat ", note}, beats, exp_n);
          end else begin
            if (beats == 0) tag = "R2";
            else if (beats % x == 0) tag = "R4";
            else tag = "R3";
            check(addr == exp_addr(base, beats, x, s), tag, {"address ", note},
                  addr, exp_addr(base, beats, x, s));
          end
          beats++;
          prev_hs = 1;
        end else begin
          hold_prev = 1;
          held = addr;
          prev_hs = 0;
        end
      end else begin
        prev_hs = 0;
      end
      addr_ready = rdy;
      if (!seen_done) begin
        @(negedge clk);
        cyc++;
      end
    end
    addr_ready = 1'b0;
    start = 1'b0;
    if (!seen_done) check(0, "R5", {"run never finished ", note}, cyc, 0);
    @(negedge clk);
    check(!done && !addr_valid, "R5", {"done one cycle ", note}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    addr_ready = 1'b0;
    base_addr = '0;
    total_qw = '0;
    stride_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!addr_valid && !done, "R1", "reset outputs", {addr_valid, done}, 0);
    @(negedge clk);
    check(!addr_valid && !done, "R1", "idle outputs", {addr_valid, done}, 0);

    for (int t = 0; t <= 9; t++)
      for (int x = 0; x <= 4; x++)
        for (int s = 0; s <= 3; s++) begin
          int seed;
          seed = t * 20 + x * 4 + s;
          run(32'h1000_0000 + 32'(seed * 37), t, x, s, seed, 1'b0, 8'h00, "sweep");
        end

    // R9: junk in unused configuration bits
    run(32'h0000_4003, 7, 3, 2, 5, 1'b0, 8'hA5, "R9 junk");
    run(32'h0000_8000, 6, 2, 1, 4, 1'b0, 8'hFF, "R9 ones");
    // R8: start while a run is in progress
    run(32'h0002_0000, 9, 2, 3, 6, 1'b1, 8'h00, "R8 poke");
    run(32'h0003_0000, 8, 4, 1, 0, 1'b1, 8'h3C, "R8 poke ready");
    // address wrap and maximal counts
    run(32'hFFFF_FFE5, 4, 1, 2, 3, 1'b0, 8'h00, "wrap");
    run(32'h0400_0000, 300, 255, 255, 0, 1'b0, 8'h00, "R4 max counts");
    run(32'h0500_0000, 0, 255, 255, 0, 1'b0, 8'h00, "R6 zero total");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule